// File: doc/BRIEF.md
# Hazard-Aware VLIW Bundle Packer

This block sits between an instruction decoder and the issue stage of a wide machine with five execution engine classes. It takes decoded operations in program order. Each operation names its engine class, up to three source register IDs and up to two destination register IDs, and carries an opaque tag. The packer groups consecutive operations into issue bundles. Operations are never reordered: each one joins the bundle that is being built unless joining would break one of three rules. That bundle is then sent out, and the operation that broke the rule becomes the first member of a fresh bundle.

The three rules are these. No operation may read a register that is already a destination in the bundle. No two operations in one bundle may write the same register. No engine class may hold more operations than its slot limit. Within each bundle, slots are grouped by engine class. A `flush` pin forces out a partly filled bundle, for example at a branch or at the end of a program. An empty bundle is never sent out.

Both streams use valid/ready handshakes. An operation is taken on a clock edge where `op_valid` and `op_ready` are both high. A bundle is handed over on an edge where `bnd_valid` and `bnd_ready` are both high. While `bnd_ready` is low, the bundle on the output stays unchanged. Operations that fit the open bundle are still accepted during that time. Only an operation that would close the open bundle is stalled, with `op_ready` low, until the output register is free or is being drained in the same cycle.

Top module: `bp_bundle_packer`

## Requirements
- R1: After reset, `bnd_valid` is 0 and `op_ready` is 1 while `flush` is low.
- R2: The default slot limits per bundle are 12 scalar ALU (engine code 0), 6 vector ALU (code 1), 2 load (code 2), 2 store (code 3) and 1 flow (code 4), which gives 23 slots. An engine's slots start at slot 0, 12, 18, 20 and 22 respectively. An operation takes the next free slot of its engine. `bnd_tags` holds the tag of slot s at bits [8s+7:8s], and `bnd_slot_vld` bit s marks slot s as occupied. Engine e's count is at `bnd_cnt` bits [4e+3:4e].
- R3: If an operation has an enabled source that matches a destination already in the open bundle, the open bundle is sent out without that operation.
- R4: If an operation has an enabled destination that matches a destination already in the open bundle, the open bundle is sent out without that operation.
- R5: If an operation's engine already holds its limit in the open bundle, the open bundle is sent out without that operation.
- R6: When a bundle is closed, its destination set and all engine counts are cleared before the operation that closed it is placed. Registers written only in the old bundle therefore cause no hazard in the new one.
- R7: Operations are packed greedily in arrival order. A run of 23 hazard-free operations that exactly fills every engine forms a single bundle, and every operation accepted ends up in exactly one emitted bundle.
- R8: While `flush` is high, `op_ready` is 0. The open bundle is sent out as soon as the output register can take it. A flush with an empty open bundle sends nothing.
- R9: While `bnd_valid` is high and `bnd_ready` is low, all bundle outputs stay stable. An operation that would close the open bundle is held off with `op_ready` low. An operation that fits is accepted.
- R10: A source or destination field whose enable bit is 0 plays no part in hazard detection.
- R11: In every emitted bundle, each engine count is within its limit, and the counts add up to the number of occupied slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is offered |
| op_ready | output | 1 | The packer takes the offered operation this cycle |
| op_eng | input | 3 | Engine class code (0..4) |
| op_tag | input | 8 | Opaque operation tag, carried into the bundle slot |
| op_src | input | 18 | Three 6-bit source register IDs, source i at bits [6i+5:6i] |
| op_src_en | input | 3 | Enable per source field |
| op_dst | input | 12 | Two 6-bit destination register IDs, destination i at bits [6i+5:6i] |
| op_dst_en | input | 2 | Enable per destination field |
| flush | input | 1 | Level request to send out the open bundle |
| bnd_valid | output | 1 | A bundle is on the output |
| bnd_ready | input | 1 | The consumer takes the bundle this cycle |
| bnd_tags | output | 184 | Slot tags, 8 bits per slot |
| bnd_slot_vld | output | 23 | Per-slot occupancy mask |
| bnd_cnt | output | 20 | Per-engine operation counts, 4 bits each |

## Verification
The checker assumes that the driver only offers engine codes 0 to 4. It also assumes that the two destinations of one operation are never the same enabled register, and that an offered operation keeps its fields unchanged until it is taken. The bench stimulus stays within these limits. Its pseudo-random phase draws the engine code modulo five. When both destinations would collide, it moves the second destination to another register. The driver task holds every field until it sees `op_ready` high. Register IDs in that phase are drawn from a small range so that read and write hazards occur often. Meanwhile the consumer side pulls `bnd_ready` low on a fixed rhythm to exercise back-pressure.

// File: rtl/bp_pkg.sv
package bp_pkg;
  localparam int NENG = 5;

  typedef enum logic [2:0] {
    ENG_ALU   = 3'd0,
    ENG_VALU  = 3'd1,
    ENG_LOAD  = 3'd2,
    ENG_STORE = 3'd3,
    ENG_FLOW  = 3'd4
  } eng_e;

  function automatic int max5(int a, int b, int c, int d, int e);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    if (e > m) m = e;
    return m;
  endfunction
endpackage

// File: rtl/bp_hazard.sv
module bp_hazard #(
  parameter int REG_N = 64,
  parameter int RW    = 6,
  parameter int NSRC  = 3,
  parameter int NDST  = 2,
  parameter int CW    = 4
) (
  input  logic [REG_N-1:0]   wset,
  input  logic [NSRC*RW-1:0] src,
  input  logic [NSRC-1:0]    src_en,
  input  logic [NDST*RW-1:0] dst,
  input  logic [NDST-1:0]    dst_en,
  input  logic [CW-1:0]      cnt,
  input  logic [CW-1:0]      lim,
  output logic               raw,
  output logic               waw,
  output logic               full
);
  always_comb begin
    raw = 1'b0;
    for (int i = 0; i < NSRC; i++)
      if (src_en[i] && wset[src[i*RW +: RW]]) raw = 1'b1;
  end

  always_comb begin
    waw = 1'b0;
    for (int i = 0; i < NDST; i++)
      if (dst_en[i] && wset[dst[i*RW +: RW]]) waw = 1'b1;
  end

  assign full = (cnt >= lim);
endmodule

// File: rtl/bp_open.sv
module bp_open #(
  parameter int REG_N = 64,
  parameter int RW    = 6,
  parameter int NDST  = 2,
  parameter int TAG_W = 8,
  parameter int SLOTS = 23,
  parameter int NENG  = 5,
  parameter int CW    = 4,
  parameter logic [NENG*8-1:0] BASES = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ins,
  input  logic                  restart,
  input  logic                  clr,
  input  logic [2:0]            eng,
  input  logic [TAG_W-1:0]      tag,
  input  logic [NDST*RW-1:0]    dst,
  input  logic [NDST-1:0]       dst_en,
  output logic [REG_N-1:0]      wset,
  output logic [NENG*CW-1:0]    cnt_flat,
  output logic [SLOTS*TAG_W-1:0] tags_flat,
  output logic [SLOTS-1:0]      svld
);
  logic [CW-1:0]    cnt_q [NENG];
  logic [CW-1:0]    cnt_d [NENG];
  logic [TAG_W-1:0] tag_q [SLOTS];
  logic [TAG_W-1:0] tag_d [SLOTS];
  logic [REG_N-1:0] wset_q, wset_d;
  logic [SLOTS-1:0] svld_q, svld_d;
  int               idx;

  always_comb begin
    wset_d = (restart || clr) ? '0 : wset_q;
    svld_d = (restart || clr) ? '0 : svld_q;
    for (int e = 0; e < NENG; e++) cnt_d[e] = (restart || clr) ? '0 : cnt_q[e];
    for (int s = 0; s < SLOTS; s++) tag_d[s] = tag_q[s];
    idx = -1;
    for (int e = 0; e < NENG; e++)
      if (ins && eng == 3'(e)) begin
        idx = int'(BASES[e*8 +: 8]) + int'(cnt_d[e]);
        cnt_d[e] = cnt_d[e] + 1'b1;
      end
    for (int s = 0; s < SLOTS; s++)
      if (s == idx) begin
        svld_d[s] = 1'b1;
        tag_d[s]  = tag;
      end
    if (ins)
      for (int i = 0; i < NDST; i++)
        if (dst_en[i]) wset_d[dst[i*RW +: RW]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wset_q <= '0;
      svld_q <= '0;
      for (int e = 0; e < NENG; e++) cnt_q[e] <= '0;
      for (int s = 0; s < SLOTS; s++) tag_q[s] <= '0;
    end else begin
      wset_q <= wset_d;
      svld_q <= svld_d;
      for (int e = 0; e < NENG; e++) cnt_q[e] <= cnt_d[e];
      for (int s = 0; s < SLOTS; s++) tag_q[s] <= tag_d[s];
    end
  end

  assign wset = wset_q;
  assign svld = svld_q;

  genvar g;
  generate
    for (g = 0; g < NENG; g++) begin : g_cnt
      assign cnt_flat[g*CW +: CW] = cnt_q[g];
    end
    for (g = 0; g < SLOTS; g++) begin : g_tag
      assign tags_flat[g*TAG_W +: TAG_W] = tag_q[g];
    end
  endgenerate
endmodule

// File: rtl/bp_outreg.sv
module bp_outreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic         valid,
  input  logic         ready,
  output logic [W-1:0] dout,
  output logic         can_load
);
  assign can_load = !valid || ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      dout  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      dout  <= din;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/bp_bundle_packer.sv
module bp_bundle_packer #(
  parameter int REG_N    = 64,
  parameter int TAG_W    = 8,
  parameter int NSRC     = 3,
  parameter int NDST     = 2,
  parameter int LIM_ALU  = 12,
  parameter int LIM_VALU = 6,
  parameter int LIM_LD   = 2,
  parameter int LIM_ST   = 2,
  parameter int LIM_FLOW = 1,
  localparam int RW    = $clog2(REG_N),
  localparam int NENG  = bp_pkg::NENG,
  localparam int SLOTS = LIM_ALU + LIM_VALU + LIM_LD + LIM_ST + LIM_FLOW,
  localparam int CW    = $clog2(bp_pkg::max5(LIM_ALU, LIM_VALU, LIM_LD, LIM_ST, LIM_FLOW) + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   op_valid,
  output logic                   op_ready,
  input  logic [2:0]             op_eng,
  input  logic [TAG_W-1:0]       op_tag,
  input  logic [NSRC*RW-1:0]     op_src,
  input  logic [NSRC-1:0]        op_src_en,
  input  logic [NDST*RW-1:0]     op_dst,
  input  logic [NDST-1:0]        op_dst_en,
  input  logic                   flush,
  output logic                   bnd_valid,
  input  logic                   bnd_ready,
  output logic [SLOTS*TAG_W-1:0] bnd_tags,
  output logic [SLOTS-1:0]       bnd_slot_vld,
  output logic [NENG*CW-1:0]     bnd_cnt
);
  localparam logic [NENG*CW-1:0] LIMS = {CW'(LIM_FLOW), CW'(LIM_ST), CW'(LIM_LD),
                                         CW'(LIM_VALU), CW'(LIM_ALU)};
  localparam logic [NENG*8-1:0] BASES = {8'(LIM_ALU + LIM_VALU + LIM_LD + LIM_ST),
                                         8'(LIM_ALU + LIM_VALU + LIM_LD),
                                         8'(LIM_ALU + LIM_VALU), 8'(LIM_ALU), 8'd0};
  localparam int OW = SLOTS*TAG_W + SLOTS + NENG*CW;

  logic [REG_N-1:0]       wset;
  logic [NENG*CW-1:0]     cnt_flat;
  logic [SLOTS*TAG_W-1:0] tags_flat;
  logic [SLOTS-1:0]       svld;
  logic [CW-1:0]          cnt_sel, lim_sel;
  logic                   raw, waw, full, conflict, can_emit, accept, emit, flush_emit;
  logic [OW-1:0]          out_q;

  always_comb begin
    cnt_sel = '0;
    lim_sel = '0;
    for (int e = 0; e < NENG; e++)
      if (op_eng == 3'(e)) begin
        cnt_sel = cnt_flat[e*CW +: CW];
        lim_sel = LIMS[e*CW +: CW];
      end
  end

  bp_hazard #(.REG_N(REG_N), .RW(RW), .NSRC(NSRC), .NDST(NDST), .CW(CW)) u_haz (
    .wset(wset), .src(op_src), .src_en(op_src_en), .dst(op_dst), .dst_en(op_dst_en),
    .cnt(cnt_sel), .lim(lim_sel), .raw(raw), .waw(waw), .full(full)
  );

  assign conflict   = raw || waw || full;
  assign op_ready   = !flush && (!conflict || can_emit);
  assign accept     = op_valid && op_ready;
  assign flush_emit = flush && (|svld) && can_emit;
  assign emit       = (accept && conflict) || flush_emit;

  bp_open #(.REG_N(REG_N), .RW(RW), .NDST(NDST), .TAG_W(TAG_W), .SLOTS(SLOTS),
            .NENG(NENG), .CW(CW), .BASES(BASES)) u_open (
    .clk(clk), .rst_n(rst_n), .ins(accept), .restart(accept && conflict), .clr(flush_emit),
    .eng(op_eng), .tag(op_tag), .dst(op_dst), .dst_en(op_dst_en),
    .wset(wset), .cnt_flat(cnt_flat), .tags_flat(tags_flat), .svld(svld)
  );

  bp_outreg #(.W(OW)) u_out (
    .clk(clk), .rst_n(rst_n), .load(emit), .din({tags_flat, svld, cnt_flat}),
    .valid(bnd_valid), .ready(bnd_ready), .dout(out_q), .can_load(can_emit)
  );

  assign {bnd_tags, bnd_slot_vld, bnd_cnt} = out_q;
endmodule

// File: rtl/bp_bundle_packer_chk.sv
module bp_bundle_packer_chk #(
  parameter int SLOTS = 23,
  parameter int TAG_W = 8,
  parameter int NENG  = 5,
  parameter int CW    = 4,
  parameter int NDST  = 2,
  parameter int RW    = 6,
  parameter logic [NENG*CW-1:0] LIMS = '0
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   op_valid,
  input logic                   op_ready,
  input logic [2:0]             op_eng,
  input logic [TAG_W-1:0]       op_tag,
  input logic [NDST*RW-1:0]     op_dst,
  input logic [NDST-1:0]        op_dst_en,
  input logic                   flush,
  input logic                   bnd_valid,
  input logic                   bnd_ready,
  input logic [SLOTS*TAG_W-1:0] bnd_tags,
  input logic [SLOTS-1:0]       bnd_slot_vld,
  input logic [NENG*CW-1:0]     bnd_cnt
);
  int cnt_sum;
  always_comb begin
    cnt_sum = 0;
    for (int e = 0; e < NENG; e++) cnt_sum += int'(bnd_cnt[e*CW +: CW]);
  end

  AST_ENG_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> (op_eng < 3'(NENG)));
  AST_DST_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (&op_dst_en)) |-> (op_dst[RW-1:0] != op_dst[2*RW-1:RW]));
  AST_OP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_ready && !flush) |=> (op_valid && $stable(op_tag) && $stable(op_eng)));
  AST_NO_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    bnd_valid |-> (|bnd_slot_vld));  // R8
  AST_FLUSH_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !op_ready);  // R8
  AST_BND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bnd_valid && !bnd_ready) |=> (bnd_valid && $stable(bnd_tags) && $stable(bnd_slot_vld) && $stable(bnd_cnt)));  // R9
  AST_CNT_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    bnd_valid |-> ($countones(bnd_slot_vld) == cnt_sum));  // R11

  genvar g;
  generate
    for (g = 0; g < NENG; g++) begin : g_lim
      AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        bnd_valid |-> (bnd_cnt[g*CW +: CW] <= LIMS[g*CW +: CW]));  // R11
    end
  endgenerate
endmodule

bind bp_bundle_packer bp_bundle_packer_chk #(
  .SLOTS(SLOTS), .TAG_W(TAG_W), .NENG(NENG), .CW(CW), .NDST(NDST), .RW(RW), .LIMS(LIMS)
) u_chk (.*);

// File: tb/bp_bundle_packer_bench.sv
module bp_bundle_packer_bench;
  localparam int TAG_W = 8;
  localparam int RW    = 6;
  localparam int SLOTS = 23;
  localparam int NENG  = 5;
  localparam int CW    = 4;
  localparam int BASE [NENG] = '{0, 12, 18, 20, 22};
  localparam int LIM  [NENG] = '{12, 6, 2, 2, 1};

  logic clk = 1'b0, rst_n = 1'b0;
  logic op_valid = 1'b0, op_ready, flush = 1'b0, bnd_valid, bnd_ready = 1'b0;
  logic [2:0] op_eng = '0;
  logic [TAG_W-1:0] op_tag = '0;
  logic [3*RW-1:0] op_src = '0;
  logic [2:0] op_src_en = '0;
  logic [2*RW-1:0] op_dst = '0;
  logic [1:0] op_dst_en = '0;
  logic [SLOTS*TAG_W-1:0] bnd_tags;
  logic [SLOTS-1:0] bnd_slot_vld;
  logic [NENG*CW-1:0] bnd_cnt;

  always #5 clk = ~clk;

  bp_bundle_packer u_bp_bundle_packer (.*);

  int errors = 0, checks = 0, cyc = 0, rdy_mode = 0;
  string cur_req = "R1";

  bit mw [64];
  int mc [NENG];
  logic [TAG_W-1:0] mt [SLOTS];
  bit mv [SLOTS];
  bit mnz = 0;

  logic [SLOTS*TAG_W-1:0] q_tags [$];
  logic [SLOTS-1:0]       q_vld [$];
  logic [NENG*CW-1:0]     q_cnt [$];
  string                  q_req [$];

  task automatic chk(bit ok, string req, string what, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    foreach (mw[i]) mw[i] = 0;
    foreach (mc[i]) mc[i] = 0;
    foreach (mv[i]) begin mv[i] = 0; mt[i] = '0; end
    mnz = 0;
  endtask

  task automatic model_push();
    logic [SLOTS*TAG_W-1:0] t = '0;
    logic [SLOTS-1:0] v = '0;
    logic [NENG*CW-1:0] c = '0;
    for (int s = 0; s < SLOTS; s++) begin
      v[s] = mv[s];
      if (mv[s]) t[s*TAG_W +: TAG_W] = mt[s];
    end
    for (int e = 0; e < NENG; e++) c[e*CW +: CW] = CW'(mc[e]);
    q_tags.push_back(t); q_vld.push_back(v); q_cnt.push_back(c); q_req.push_back(cur_req);
    model_clear();
  endtask

  task automatic send(int eng, int tag, int s0, int s1, int s2, bit [2:0] sen,
                      int d0, int d1, bit [1:0] den);
    bit hz;
    @(negedge clk);
    op_valid = 1; op_eng = 3'(eng); op_tag = TAG_W'(tag);
    op_src = {RW'(s2), RW'(s1), RW'(s0)}; op_src_en = sen;
    op_dst = {RW'(d1), RW'(d0)}; op_dst_en = den;
    forever begin
      #2;
      if (op_ready) break;
      @(negedge clk);
    end
    hz = (sen[0] && mw[s0]) || (sen[1] && mw[s1]) || (sen[2] && mw[s2]) ||
         (den[0] && mw[d0]) || (den[1] && mw[d1]) || (mc[eng] >= LIM[eng]);
    if (hz) model_push();
    mv[BASE[eng] + mc[eng]] = 1;
    mt[BASE[eng] + mc[eng]] = TAG_W'(tag);
    mc[eng]++;
    if (den[0]) mw[d0] = 1;
    if (den[1]) mw[d1] = 1;
    mnz = 1;
    @(posedge clk);
    #1 op_valid = 0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    op_valid = 0; flush = 1;
    #2 chk(op_ready == 0, "R8", "op_ready during flush", op_ready, 0);
    if (mnz) begin
      forever begin
        if (!bnd_valid || bnd_ready) break;
        @(negedge clk); #2;
      end
      model_push();
    end
    @(posedge clk);
    #1 flush = 0;
  endtask

  // monitor / scoreboard
  logic [SLOTS*TAG_W-1:0] h_tags;
  logic [SLOTS-1:0] h_vld;
  logic [NENG*CW-1:0] h_cnt;
  bit had_hold = 0;
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      bnd_ready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? (cyc % 3 != 0) : 1'b0;
      #1;
      if (!rst_n) continue;
      if (had_hold)
        chk(bnd_valid && bnd_tags == h_tags && bnd_slot_vld == h_vld && bnd_cnt == h_cnt,
            "R9", "bundle held stable", {bnd_valid, bnd_slot_vld}, {1'b1, h_vld});
      had_hold = bnd_valid && !bnd_ready;
      h_tags = bnd_tags; h_vld = bnd_slot_vld; h_cnt = bnd_cnt;
      if (bnd_valid && bnd_ready) begin
        if (q_vld.size() == 0) begin
          chk(0, cur_req, "unexpected bundle", bnd_slot_vld, 0);
        end else begin
          logic [SLOTS*TAG_W-1:0] et, mt_mask;
          logic [SLOTS-1:0] ev;
          logic [NENG*CW-1:0] ec;
          string rq;
          et = q_tags.pop_front(); ev = q_vld.pop_front(); ec = q_cnt.pop_front(); rq = q_req.pop_front();
          mt_mask = '0;
          for (int s = 0; s < SLOTS; s++) if (bnd_slot_vld[s]) mt_mask[s*TAG_W +: TAG_W] = '1;
          chk(bnd_slot_vld == ev, rq, "slot mask (R2)", bnd_slot_vld, ev);
          chk((bnd_tags & mt_mask) == et, rq, "slot tags (R2)", bnd_tags & mt_mask, et);
          chk(bnd_cnt == ec, rq, "engine counts (R11)", bnd_cnt, ec);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", "run did not finish", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    model_clear();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk); #2;
    chk(bnd_valid == 0, "R1", "bnd_valid after reset", bnd_valid, 0);
    chk(op_ready == 1, "R1", "op_ready after reset", op_ready, 1);

    // R7 / R2: 23 hazard-free ops fill all engines, round robin; 24th ALU closes it (R5)
    cur_req = "R7";
    begin
      int n [NENG];
      int t;
      foreach (n[i]) n[i] = 0;
      t = 1;
      while (t <= 23) begin
        for (int e = 0; e < NENG; e++)
          if (n[e] < LIM[e]) begin
            send(e, t, 0, 0, 0, 3'b000, 20 + t, 0, (e < 3) ? 2'b01 : 2'b00);
            n[e]++; t++;
          end
      end
    end
    cur_req = "R5";
    send(0, 24, 0, 0, 0, 3'b000, 50, 0, 2'b01);
    do_flush();

    // R3 and R6: RAW closes; new bundle does not remember old writes
    cur_req = "R3";
    send(0, 8'h31, 0, 0, 0, 3'b000, 5, 0, 2'b01);
    send(1, 8'h32, 9, 5, 0, 3'b011, 6, 0, 2'b01);
    cur_req = "R6";
    send(2, 8'h33, 0, 0, 0, 3'b000, 5, 0, 2'b01);
    do_flush();

    // R4: WAW on second destination field
    cur_req = "R4";
    send(1, 8'h41, 0, 0, 0, 3'b000, 7, 8, 2'b11);
    send(1, 8'h42, 0, 0, 0, 3'b000, 3, 8, 2'b11);
    do_flush();

    // R5: flow limit 1, load limit 2
    cur_req = "R5";
    send(4, 8'h51, 0, 0, 0, 3'b000, 0, 0, 2'b00);
    send(4, 8'h52, 0, 0, 0, 3'b000, 0, 0, 2'b00);
    send(2, 8'h53, 0, 0, 0, 3'b000, 0, 0, 2'b00);
    send(2, 8'h54, 0, 0, 0, 3'b000, 0, 0, 2'b00);
    send(2, 8'h55, 0, 0, 0, 3'b000, 0, 0, 2'b00);
    do_flush();

    // R10: disabled fields naming a written register do not close
    cur_req = "R10";
    send(0, 8'h61, 0, 0, 0, 3'b000, 11, 0, 2'b01);
    send(0, 8'h62, 11, 11, 11, 3'b000, 12, 11, 2'b01);
    do_flush();

    // R8: flush with nothing open sends nothing
    cur_req = "R8";
    do_flush();
    repeat (3) @(negedge clk);
    #2 chk(bnd_valid == 0, "R8", "no bundle from empty flush", bnd_valid, 0);

    // R9: stall of a closing op while output is occupied
    cur_req = "R9";
    rdy_mode = 2;
    send(0, 8'h71, 0, 0, 0, 3'b000, 1, 0, 2'b01);
    send(0, 8'h72, 0, 0, 0, 3'b000, 1, 0, 2'b01);
    send(1, 8'h73, 0, 0, 0, 3'b000, 9, 0, 2'b01);
    @(negedge clk);
    op_valid = 1; op_eng = 3'd0; op_tag = 8'h74; op_src_en = 3'b000;
    op_dst = {6'd0, 6'd1}; op_dst_en = 2'b01;
    #2 chk(op_ready == 0, "R9", "closing op stalled", op_ready, 0);
    repeat (3) @(negedge clk);
    #2 chk(op_ready == 0, "R9", "closing op still stalled", op_ready, 0);
    rdy_mode = 0;
    send(0, 8'h74, 0, 0, 0, 3'b000, 1, 0, 2'b01);
    do_flush();

    // mixed pseudo-random stream under back-pressure
    cur_req = "R7";
    rdy_mode = 1;
    lf = 16'hACE1;
    for (int k = 0; k < 300; k++) begin
      int d0, d1;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      d0 = int'(lf[3:0]);
      d1 = int'(lf[7:4]);
      if (d1 == d0) d1 = 16 + d0;
      send(int'(lf[10:8]) % 5, k, int'(lf[11:8]), int'(lf[15:12]), int'(lf[6:3]),
           lf[2:0], d0, d1, lf[13:12]);
    end
    do_flush();
    rdy_mode = 0;
    repeat (10) @(negedge clk);
    #2 chk(q_vld.size() == 0, "R7", "all expected bundles seen", q_vld.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule